// File: doc/BRIEF.md
# Migrated Sub-Page Address Redirector

This block sits in a memory controller's request path and rewrites the physical address of every request into the DRAM address that actually holds the data. A small region at the bottom of every bank (the lowest 16 rows of each bank of each DIMM) is set aside for 1 KB sub-pages that a migration engine has moved there because they are accessed often. The block keeps one table entry per reserved 1 KB slot (4096 of them). Each entry records which original sub-page now lives in that slot. When a request's sub-page number matches a valid entry, the entry's slot index becomes the new DIMM, bank, row and column-high bits. Otherwise the address passes through unchanged.

Sub-pages only move within their own DIMM, so a lookup compares the request against just the 512 entries that belong to the request's DIMM. Lookups run in a two-stage pipeline with a valid/ready handshake on both sides. This lets the translation overlap with request queueing. A migration engine writes and invalidates entries through dedicated ports. A reverse port reads an entry by slot index, so the occupant can be copied back to its home location.

Each pipeline stage is a two-state machine. The states are STG_EMPTY and STG_LOADED, and each stage has these transitions:

- Search stage:
  - Fill (EMPTY to LOADED) on an accepted request.
  - Drain (LOADED to EMPTY) when its contents move on and no new request arrives.
  - Refill (LOADED to LOADED) when it moves on and a new request is accepted in the same cycle.
- Output stage:
  - Fill on a move from the search stage.
  - Drain when the response is taken and nothing moves in.
  - Refill when the response is taken and a new result moves in.

Top module: `subpage_redirect`

## Requirements
- R1: After reset every entry is invalid, so all lookups miss. After reset `rsp_valid` and `rev_valid` are low and `req_ready` is high.
- R2: A lookup that matches no valid entry returns `rsp_hit`=0 and `rsp_addr` equal to `req_addr`.
- R3: A lookup matches an entry when the entry is valid and its stored tag equals `req_addr[31:10]`. The slot index is {dimm[11:9], bank[8:7], row[6:3], sub[2:0]}. On a match, `rsp_hit`=1 and `rsp_addr` = {dimm, 10'b0, row, bank, sub, req_addr[9:0]}. In that result, bits [31:29] hold the DIMM, [28:19] are zero, [18:15] hold the row, [14:13] hold the bank and [12:10] hold the sub-slot.
- R4: Only entries whose slot DIMM field (slot[11:9]) equals `req_addr[31:29]` are searched. An entry of another DIMM never matches, whatever tag it holds.
- R5: When several searched entries match, the one with the lowest slot index is used.
- R6: A request is accepted when `req_valid` and `req_ready` are both high. Its result appears with `rsp_valid` high two cycles after acceptance when the output is not stalled. One request can be accepted every cycle.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_addr` and `rsp_hit` stay unchanged. Responses are never lost or duplicated, and they leave in acceptance order.
- R8: `wr_en` stores `wr_tag` in slot `wr_slot` and marks it valid for lookups accepted in later cycles. A lookup accepted in the same cycle as the write sees the old contents.
- R9: `inv_en` marks slot `inv_slot` invalid for later lookups. When a write and an invalidate target the same slot in the same cycle, the write takes effect.
- R10: `rev_en` in a cycle gives `rev_valid` high for exactly the next cycle. In that cycle `rev_occupied` is the slot's valid bit, and `rev_addr` is {tag, 10'b0} when the slot is occupied and 0 when it is not. A write to the same slot in the same cycle as `rev_en` is not seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be accepted |
| req_addr | input | 32 | Physical address to translate |
| rsp_valid | output | 1 | Translated address present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 32 | DRAM address to use |
| rsp_hit | output | 1 | Address was redirected into the reserved region |
| wr_en | input | 1 | Write a table entry |
| wr_slot | input | 12 | Slot index written |
| wr_tag | input | 22 | Original sub-page number stored |
| inv_en | input | 1 | Invalidate a table entry |
| inv_slot | input | 12 | Slot index invalidated |
| rev_en | input | 1 | Reverse lookup request |
| rev_slot | input | 12 | Slot index read back |
| rev_valid | output | 1 | Reverse lookup result present |
| rev_occupied | output | 1 | The slot holds a valid entry |
| rev_addr | output | 32 | Original base address of the occupant |

## Verification
The assertions assume that the inputs never carry X or Z values once reset is released. They also assume that write, invalidate and reverse-read pulses are all sampled on the same clock as lookups. The reverse-read property further relies on the slot index of the write being the one read back in the following cycle. The bench drives every input from tasks one time unit after the rising edge, so all of them hold defined values for the whole cycle. Tags are built from a fixed pool, so both hits and misses in every DIMM occur often. Backpressure is exercised only in the randomized phase, where the cycle-exact latency comparison is switched off and only ordering and hold behaviour are compared.

// File: rtl/subpage_redirect_pkg.sv
package subpage_redirect_pkg;

    // Address geometry
    localparam int ADDR_W  = 32;
    localparam int LOW_W   = 10;   // bits kept from the request (1 KB sub-page)
    localparam int SUB_W   = 3;    // 1 KB slots per 8 KB row
    localparam int BANK_W  = 2;
    localparam int ROW_W   = 14;
    localparam int DIMM_W  = 3;
    localparam int RROW_W  = 4;    // reserved rows per bank

    localparam int BANK_LO = LOW_W + SUB_W;
    localparam int ROW_LO  = BANK_LO + BANK_W;
    localparam int DIMM_LO = ROW_LO + ROW_W;

    // Table geometry
    localparam int TAG_W    = ADDR_W - LOW_W;
    localparam int SLOT_W   = DIMM_W + BANK_W + RROW_W + SUB_W;
    localparam int N_SLOTS  = 1 << SLOT_W;
    localparam int IDX_W    = SLOT_W - DIMM_W;
    localparam int PER_DIMM = 1 << IDX_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic {
        STG_EMPTY  = 1'b0,
        STG_LOADED = 1'b1
    } stage_e;

endpackage

// File: rtl/subpage_redirect_table.sv
module subpage_redirect_table
    import subpage_redirect_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  slot_t             wr_slot,
    input  tag_t              wr_tag,
    input  logic              inv_en,
    input  slot_t             inv_slot,
    input  logic [DIMM_W-1:0] sel_dimm,
    output tag_t              grp_tag [PER_DIMM],
    output logic [PER_DIMM-1:0] grp_vld,
    input  logic              rd_en,
    input  slot_t             rd_slot,
    output logic              rd_valid,
    output logic              rd_occ,
    output tag_t              rd_tag
);

    tag_t               tag_mem [N_SLOTS];
    logic [N_SLOTS-1:0] vld;

    // Tag storage needs no reset: the valid vector qualifies every use.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_slot] <= wr_tag;
        end
    end

    // Write is assigned last, so it overrides an invalidate of the same slot.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            if (inv_en) begin
                vld[inv_slot] <= 1'b0;
            end
            if (wr_en) begin
                vld[wr_slot] <= 1'b1;
            end
        end
    end

    // The entries of one DIMM are presented to the search logic.
    always_comb begin
        for (int j = 0; j < PER_DIMM; j++) begin
            grp_tag[j] = tag_mem[{sel_dimm, IDX_W'(j)}];
            grp_vld[j] = vld[{sel_dimm, IDX_W'(j)}];
        end
    end

    // Registered reverse read: sees contents from before this edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_occ   <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_occ <= vld[rd_slot];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_tag <= tag_mem[rd_slot];
        end
    end

endmodule

// File: rtl/subpage_redirect_search.sv
module subpage_redirect_search
    import subpage_redirect_pkg::*;
(
    input  tag_t               key,
    input  tag_t               grp_tag [PER_DIMM],
    input  logic [PER_DIMM-1:0] grp_vld,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    logic [PER_DIMM-1:0] match;

    for (genvar g = 0; g < PER_DIMM; g++) begin : g_cmp
        assign match[g] = grp_vld[g] && (grp_tag[g] == key);
    end

    // Scanning downward leaves the lowest matching index in idx.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int j = PER_DIMM - 1; j >= 0; j--) begin
            if (match[j]) begin
                found = 1'b1;
                idx   = IDX_W'(j);
            end
        end
    end

endmodule

// File: rtl/subpage_redirect_remap.sv
module subpage_redirect_remap
    import subpage_redirect_pkg::*;
(
    input  logic  hit,
    input  slot_t slot,
    input  addr_t orig,
    output addr_t remapped
);

    always_comb begin
        remapped = orig;
        if (hit) begin
            remapped                       = '0;
            remapped[LOW_W-1:0]            = orig[LOW_W-1:0];
            remapped[LOW_W +: SUB_W]       = slot[0 +: SUB_W];
            remapped[ROW_LO +: RROW_W]     = slot[SUB_W +: RROW_W];
            remapped[BANK_LO +: BANK_W]    = slot[SUB_W + RROW_W +: BANK_W];
            remapped[DIMM_LO +: DIMM_W]    = slot[IDX_W +: DIMM_W];
        end
    end

endmodule

// File: rtl/subpage_redirect.sv
module subpage_redirect
    import subpage_redirect_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_hit,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              inv_en,
    input  logic [SLOT_W-1:0] inv_slot,
    input  logic              rev_en,
    input  logic [SLOT_W-1:0] rev_slot,
    output logic              rev_valid,
    output logic              rev_occupied,
    output logic [ADDR_W-1:0] rev_addr
);

    // Pipeline control
    stage_e s1_st, s1_nx;
    stage_e s2_st, s2_nx;
    logic   req_fire, s1_move, s2_free;

    // Table and search interconnect
    tag_t               grp_tag [PER_DIMM];
    logic [PER_DIMM-1:0] grp_vld;
    logic               srch_found;
    logic [IDX_W-1:0]   srch_idx;
    tag_t               rev_tag;

    // Stage registers
    addr_t s1_addr;
    logic  s1_hit;
    slot_t s1_slot;
    addr_t s1_remap;
    addr_t s2_addr;
    logic  s2_hit;

    subpage_redirect_table u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_tag   (wr_tag),
        .inv_en   (inv_en),
        .inv_slot (inv_slot),
        .sel_dimm (req_addr[DIMM_LO +: DIMM_W]),
        .grp_tag  (grp_tag),
        .grp_vld  (grp_vld),
        .rd_en    (rev_en),
        .rd_slot  (rev_slot),
        .rd_valid (rev_valid),
        .rd_occ   (rev_occupied),
        .rd_tag   (rev_tag)
    );

    subpage_redirect_search u_search (
        .key     (req_addr[ADDR_W-1:LOW_W]),
        .grp_tag (grp_tag),
        .grp_vld (grp_vld),
        .found   (srch_found),
        .idx     (srch_idx)
    );

    subpage_redirect_remap u_remap (
        .hit      (s1_hit),
        .slot     (s1_slot),
        .orig     (s1_addr),
        .remapped (s1_remap)
    );

    // Handshake decode
    assign s2_free   = (s2_st == STG_EMPTY) || rsp_ready;
    assign s1_move   = (s1_st == STG_LOADED) && s2_free;
    assign req_ready = (s1_st == STG_EMPTY) || s2_free;
    assign req_fire  = req_valid && req_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_st <= STG_EMPTY;
            s2_st <= STG_EMPTY;
        end else begin
            s1_st <= s1_nx;
            s2_st <= s2_nx;
        end
    end

    // Next-state logic
    always_comb begin
        s1_nx = s1_st;
        unique case (s1_st)
            STG_EMPTY:  if (req_fire)              s1_nx = STG_LOADED;
            STG_LOADED: if (s1_move && !req_fire)  s1_nx = STG_EMPTY;
            default:                               s1_nx = STG_EMPTY;
        endcase
        s2_nx = s2_st;
        unique case (s2_st)
            STG_EMPTY:  if (s1_move)               s2_nx = STG_LOADED;
            STG_LOADED: if (rsp_ready && !s1_move) s2_nx = STG_EMPTY;
            default:                               s2_nx = STG_EMPTY;
        endcase
    end

    // Search stage: the table is compared in the acceptance cycle.
    always_ff @(posedge clk) begin
        if (req_fire) begin
            s1_addr <= req_addr;
            s1_hit  <= srch_found;
            s1_slot <= {req_addr[DIMM_LO +: DIMM_W], srch_idx};
        end
    end

    // Output stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_addr <= '0;
            s2_hit  <= 1'b0;
        end else if (s1_move) begin
            s2_addr <= s1_remap;
            s2_hit  <= s1_hit;
        end
    end

    // Outputs
    assign rsp_valid = (s2_st == STG_LOADED);
    assign rsp_addr  = s2_addr;
    assign rsp_hit   = s2_hit;
    assign rev_addr  = rev_occupied ? {rev_tag, {LOW_W{1'b0}}} : '0;

endmodule

// File: rtl/subpage_redirect_chk.sv
module subpage_redirect_chk
    import subpage_redirect_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              rsp_hit,
    input logic              wr_en,
    input logic [SLOT_W-1:0] wr_slot,
    input logic [TAG_W-1:0]  wr_tag,
    input logic              rev_en,
    input logic [SLOT_W-1:0] rev_slot,
    input logic              rev_valid,
    input logic              rev_occupied,
    input logic [ADDR_W-1:0] rev_addr
);

    // R6: an accepted request is presented two cycles later unless stalled
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) ##1 (!rsp_valid || rsp_ready) |=> rsp_valid);

    // R7: a stalled response holds
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_hit)));

    // R3: a redirected address lies in the reserved rows
    p_hit_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_addr[DIMM_LO-1:ROW_LO+RROW_W] == '0));

    // R10: reverse result is a one-cycle echo of the request
    p_rev_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rev_en |=> rev_valid);

    p_rev_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rev_en |=> !rev_valid);

    // R8: a written entry is seen by a reverse read in the next cycle
    p_wr_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en ##1 (rev_en && (rev_slot == $past(wr_slot)))
        |=> (rev_occupied && (rev_addr[ADDR_W-1:LOW_W] == $past(wr_tag, 2))));

endmodule

bind subpage_redirect subpage_redirect_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_addr     (rsp_addr),
    .rsp_hit      (rsp_hit),
    .wr_en        (wr_en),
    .wr_slot      (wr_slot),
    .wr_tag       (wr_tag),
    .rev_en       (rev_en),
    .rev_slot     (rev_slot),
    .rev_valid    (rev_valid),
    .rev_occupied (rev_occupied),
    .rev_addr     (rev_addr)
);

// File: tb/subpage_redirect_test.sv
module subpage_redirect_test;
    import subpage_redirect_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic        rst_n;
    logic        req_valid, req_ready, rsp_valid, rsp_ready, rsp_hit;
    logic [31:0] req_addr, rsp_addr, rev_addr;
    logic        wr_en, inv_en, rev_en, rev_valid, rev_occupied;
    logic [11:0] wr_slot, inv_slot, rev_slot;
    logic [21:0] wr_tag;

    subpage_redirect uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_hit(rsp_hit),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_tag(wr_tag),
        .inv_en(inv_en), .inv_slot(inv_slot),
        .rev_en(rev_en), .rev_slot(rev_slot),
        .rev_valid(rev_valid), .rev_occupied(rev_occupied), .rev_addr(rev_addr)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    timed = 1'b1;
    bit    done  = 1'b0;
    bit    live  = 1'b0;
    string hit_tag  = "R3";
    string miss_tag = "R2";

    // Behavioural reference state
    bit          ref_vld [4096];
    logic [21:0] ref_tag [4096];

    typedef struct {
        logic [32:0] val;   // {hit, addr}
        int          cyc;
        string       tag;
    } exp_t;
    exp_t q[$];

    typedef struct {
        bit          occ;
        logic [31:0] addr;
    } rev_t;
    rev_t rq[$];

    bit          prev_stall = 1'b0;
    logic [32:0] prev_val;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [32:0] act, input logic [32:0] expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [11:0] mk_slot(input int d, input int b, input int r, input int s);
        return 12'(d * 512 + b * 128 + r * 8 + s);
    endfunction

    function automatic exp_t ref_lookup(input logic [31:0] a);
        exp_t e;
        int   d;
        e.val = {1'b0, a};
        e.cyc = cyc;
        e.tag = miss_tag;
        d = int'(a[31:29]);
        for (int j = 0; j < 512; j++) begin
            int s;
            s = d * 512 + j;
            if (ref_vld[s] && ref_tag[s] == a[31:10]) begin
                e.val = {1'b1, 3'(s / 512), 10'd0, 4'((s / 8) % 16),
                         2'((s / 128) % 4), 3'(s % 8), a[9:0]};
                e.tag = hit_tag;
                break;
            end
        end
        return e;
    endfunction

    // Monitor and reference model, evaluated away from the rising edge
    always @(negedge clk) begin
        if (live && !done) begin
            cyc++;
            if (prev_stall)
                chk(rsp_valid && {rsp_hit, rsp_addr} == prev_val, "R7", "stalled response changed",
                    {rsp_hit, rsp_addr}, prev_val);
            if (timed) begin
                bit ev;
                ev = (q.size() > 0) && (q[0].cyc + 2 == cyc);
                chk(rsp_valid == ev, "R6", "rsp_valid timing", 33'(rsp_valid), 33'(ev));
            end
            if (rsp_valid && rsp_ready) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R7", "response with nothing pending", {rsp_hit, rsp_addr}, 33'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk({rsp_hit, rsp_addr} == e.val, e.tag, "response {hit,addr}",
                        {rsp_hit, rsp_addr}, e.val);
                end
            end
            prev_stall = rsp_valid && !rsp_ready;
            prev_val   = {rsp_hit, rsp_addr};
            if (rq.size() > 0) begin
                rev_t r;
                r = rq.pop_front();
                chk(rev_valid && rev_occupied == r.occ && rev_addr == r.addr, "R10",
                    "reverse {occ,addr}", {rev_occupied, rev_addr}, {r.occ, r.addr});
            end else begin
                chk(!rev_valid, "R10", "spurious rev_valid", 33'(rev_valid), 33'd0);
            end
            // Events taking effect at the coming edge; lookups and reads see old contents
            if (req_valid && req_ready) q.push_back(ref_lookup(req_addr));
            if (rev_en) begin
                rev_t r;
                r.occ  = ref_vld[rev_slot];
                r.addr = ref_vld[rev_slot] ? {ref_tag[rev_slot], 10'd0} : 32'd0;
                rq.push_back(r);
            end
            if (inv_en) ref_vld[inv_slot] = 1'b0;
            if (wr_en) begin
                ref_vld[wr_slot] = 1'b1;
                ref_tag[wr_slot] = wr_tag;
            end
        end
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic lookup(input logic [31:0] a);
        bit acc;
        req_valid = 1'b1;
        req_addr  = a;
        do begin
            @(negedge clk);
            acc = req_ready;
            @(posedge clk);
            #1;
        end while (!acc);
        req_valid = 1'b0;
    endtask

    task automatic write_entry(input logic [11:0] s, input logic [21:0] t);
        wr_en = 1'b1; wr_slot = s; wr_tag = t;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic inval(input logic [11:0] s);
        inv_en = 1'b1; inv_slot = s;
        tick();
        inv_en = 1'b0;
    endtask

    task automatic rev_read(input logic [11:0] s);
        rev_en = 1'b1; rev_slot = s;
        tick();
        rev_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    function automatic logic [21:0] pool_tag(input int i);
        return {3'(i % 8), 19'(i * 977 + 3)};
    endfunction

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL R6 watchdog expired actual=%0d expected=completion", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        logic [21:0] ta, tb;
        for (int i = 0; i < 4096; i++) begin
            ref_vld[i] = 1'b0;
            ref_tag[i] = '0;
        end
        rst_n = 1'b0;
        req_valid = 1'b0; req_addr = '0; rsp_ready = 1'b1;
        wr_en = 1'b0; wr_slot = '0; wr_tag = '0;
        inv_en = 1'b0; inv_slot = '0; rev_en = 1'b0; rev_slot = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_valid, "R1", "rsp_valid after reset", 33'(rsp_valid), 33'd0);
        chk(req_ready,  "R1", "req_ready after reset", 33'(req_ready), 33'd1);
        chk(!rev_valid, "R1", "rev_valid after reset", 33'(rev_valid), 33'd0);
        @(posedge clk); #1;
        live = 1'b1;

        // R1: cleared table, every lookup misses
        miss_tag = "R1";
        lookup(32'h0000_0000); lookup(32'hFFFF_FFFF); lookup(32'h4000_0400);
        rev_read(12'd0); rev_read(12'd4095);
        idle(3);

        // R2: pass-through of unmatched addresses
        miss_tag = "R2";
        lookup(32'h1234_5678); lookup(32'hA5A5_5A5A); lookup(32'h7FFF_FC00);
        idle(3);

        // R3 / R8: redirected hits, including extreme slots
        hit_tag = "R3";
        write_entry(mk_slot(2, 1, 5, 3), {3'd2, 19'h01234});
        write_entry(12'd0,    {3'd0, 19'h00007});
        write_entry(12'd4095, {3'd7, 19'h7FFFF});
        write_entry(12'd511,  {3'd0, 19'h00ABC});
        lookup({3'd2, 19'h01234, 10'h2A5});
        lookup({3'd0, 19'h00007, 10'h3FF});
        lookup({3'd7, 19'h7FFFF, 10'h000});
        lookup({3'd0, 19'h00ABC, 10'h155});
        idle(3);

        // R4: an entry in another DIMM's slots never matches
        miss_tag = "R4";
        write_entry(mk_slot(1, 0, 0, 0), {3'd5, 19'h00555});
        lookup({3'd5, 19'h00555, 10'h011});
        idle(3);

        // R5: duplicate tags, lowest slot wins
        hit_tag = "R5";
        write_entry(mk_slot(3, 2, 9, 6), {3'd3, 19'h0BEEF});
        write_entry(mk_slot(3, 0, 1, 2), {3'd3, 19'h0BEEF});
        write_entry(mk_slot(3, 3, 15, 7), {3'd3, 19'h0BEEF});
        lookup({3'd3, 19'h0BEEF, 10'h0F0});
        idle(3);

        // R8: write in the acceptance cycle is not seen; later lookups see it
        hit_tag = "R8"; miss_tag = "R8";
        ta = {3'd2, 19'h01234};
        tb = {3'd2, 19'h04321};
        wr_en = 1'b1; wr_slot = mk_slot(2, 1, 5, 3); wr_tag = tb;
        req_valid = 1'b1; req_addr = {ta, 10'h001};
        tick();
        wr_en = 1'b0; req_valid = 1'b0;
        lookup({ta, 10'h002});
        lookup({tb, 10'h003});
        idle(3);

        // R9: invalidate, then write beating invalidate on the same slot
        hit_tag = "R9"; miss_tag = "R9";
        inval(12'd0);
        lookup({3'd0, 19'h00007, 10'h004});
        inv_en = 1'b1; inv_slot = 12'd4095;
        wr_en = 1'b1; wr_slot = 12'd4095; wr_tag = {3'd7, 19'h12345};
        tick();
        inv_en = 1'b0; wr_en = 1'b0;
        lookup({3'd7, 19'h12345, 10'h005});
        idle(3);

        // R10: reverse reads, occupied and empty, and same-cycle write
        rev_read(mk_slot(3, 0, 1, 2));
        rev_read(12'd0);
        rev_read(12'd4095);
        rev_en = 1'b1; rev_slot = 12'd100;
        wr_en = 1'b1; wr_slot = 12'd100; wr_tag = {3'd0, 19'h00100};
        tick();
        rev_en = 1'b0; wr_en = 1'b0;
        rev_read(12'd100);
        idle(3);

        // R6: back-to-back stream, one accept per cycle
        hit_tag = "R6"; miss_tag = "R6";
        for (int i = 0; i < 24; i++) begin
            req_valid = 1'b1;
            req_addr = (i % 2 == 0) ? {3'd3, 19'h0BEEF, 10'(i)} : {10'(i * 37), 22'(i * 911)};
            tick();
        end
        req_valid = 1'b0;
        idle(4);

        // R7: random traffic under backpressure
        timed = 1'b0;
        hit_tag = "R7"; miss_tag = "R7";
        for (int i = 0; i < 4000; i++) begin
            int p;
            p = int'($urandom % 32);
            req_valid = ($urandom % 4) != 0;
            req_addr  = ($urandom % 4 != 0) ? {pool_tag(p), 10'($urandom)} : 32'($urandom);
            rsp_ready = ($urandom % 3) != 0;
            wr_en     = ($urandom % 5) == 0;
            wr_tag    = pool_tag(int'($urandom % 32));
            wr_slot   = ($urandom % 8 != 0) ? {wr_tag[21:19], 9'($urandom % 16)} : 12'($urandom);
            inv_en    = ($urandom % 9) == 0;
            inv_slot  = {3'($urandom), 9'($urandom % 16)};
            rev_en    = ($urandom % 6) == 0;
            rev_slot  = {3'($urandom), 9'($urandom % 16)};
            tick();
        end
        req_valid = 1'b0; wr_en = 1'b0; inv_en = 1'b0; rev_en = 1'b0;
        rsp_ready = 1'b1;
        idle(8);
        chk(q.size() == 0, "R7", "responses left undelivered", 33'(q.size()), 33'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule